// File: doc/BRIEF.md
# Paired PWM Clock Source

This block produces the shared timebase for one pair of PWM channels. It picks one of two reference tick enables, one from the crystal oscillator and one from the bus clock domain, and passes it through a gate. It then divides it by a power of two and emits a one-cycle source tick that both channels of the pair count on. The block runs entirely on one fast system clock. The references and the output are clock enables, not clocks, so no clock cells or glitch-free muxes are involved.

A single configuration word drives the stage: the source select, the gate, the divider exponent, and one bypass-select bit per channel. The bypass bits are only held and handed to the channels; they do not change the source tick. A chip with six channels uses three instances, one per pair, and each instance has its own word. A new source or exponent written while the gate is on is held back until the current divided period ends, so the channels never see a short period.

Top module: `pwm_pair_clksrc`

## Requirements
- R1: Bit 7 of the configuration word selects the reference: 0 takes `oscTick`, 1 takes `busTick`. Output ticks come only from ticks of the selected input, and the other input has no effect.
- R2: Bit 4 is the gate. While it is 0, `srcTick` stays low and the divider count is cleared. After it goes to 1, the first `srcTick` follows the 2^m-th selected reference tick.
- R3: Bits 3:0 hold an exponent m. `srcTick` pulses for one cycle on every 2^m-th selected reference tick, for m from 0 to 8. The pulse comes one clock after the reference tick that completes the count.
- R4: Exponent values 9 to 15 divide by 256, the same as m = 8.
- R5: `bypassEven` follows bit 5 and `bypassOdd` follows bit 6, each one clock after the word, whatever the state of the gate.
- R6: While the gate is on, a new exponent or source select takes effect only at the next `srcTick`. The period in progress completes with the old settings.
- R7: During reset `srcTick`, `bypassEven` and `bypassOdd` are low and the divider count is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| oscTick | input | 1 | Oscillator reference tick enable |
| busTick | input | 1 | Bus clock reference tick enable |
| cfgWord | input | CFG_W (8) | Pair configuration word: bit 7 source select, bits 6 and 5 odd and even bypass, bit 4 gate, bits 3:0 exponent |
| srcTick | output | 1 | Divided source tick for both channels of the pair |
| bypassEven | output | 1 | Bypass select for the even channel |
| bypassOdd | output | 1 | Bypass select for the odd channel |

## Verification
The bypass flags are due one clock after the word changes. A `srcTick` is due one clock after the reference tick that completes a count. After the gate opens, the first tick is due after 2^m selected reference ticks. The bench drives and samples on the falling edge. For division ratios it measures the number of falling edges between two consecutive source ticks, so the fixed pipeline delay cancels and only the ratio is checked. Only the gate restart check counts from the stimulus edge, and it expects the tick on the fourth falling edge for m = 2 with a reference tick every cycle.

// File: rtl/pwm_pair_clksrc_pkg.sv
package pwm_pair_clksrc_pkg;
  localparam int EXP_W   = 4;
  localparam int EXP_LSB = 0;
  localparam int GATE_BIT   = 4;
  localparam int BYP_EVEN_BIT = 5;
  localparam int BYP_ODD_BIT  = 6;
  localparam int SEL_BIT    = 7;

  typedef struct packed {
    logic             refTick;
    logic             gateOn;
    logic [EXP_W-1:0] divExp;
  } pairStrobe_t;
endpackage

// File: rtl/pwm_pair_clksrc_ctrl.sv
module pwm_pair_clksrc_ctrl
  import pwm_pair_clksrc_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int MAX_EXP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             busTick,
  input  logic [CFG_W-1:0] cfgWord,
  input  logic             wrapNow,
  output pairStrobe_t      strobes,
  output logic             bypassEven,
  output logic             bypassOdd
);
  localparam logic [EXP_W-1:0] EXP_CAP = EXP_W'(MAX_EXP);

  logic             actSel;
  logic [EXP_W-1:0] actM;
  logic [EXP_W-1:0] cfgExp;
  logic [EXP_W-1:0] expClamp;
  logic             cfgGate;
  logic             reload;

  assign cfgExp   = cfgWord[EXP_LSB +: EXP_W];
  assign expClamp = (cfgExp > EXP_CAP) ? EXP_CAP : cfgExp;
  assign cfgGate  = cfgWord[GATE_BIT];
  assign reload   = !cfgGate || wrapNow;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      actSel     <= 1'b0;
      actM       <= '0;
      bypassEven <= 1'b0;
      bypassOdd  <= 1'b0;
    end else begin
      bypassEven <= cfgWord[BYP_EVEN_BIT];
      bypassOdd  <= cfgWord[BYP_ODD_BIT];
      if (reload) begin
        actSel <= cfgWord[SEL_BIT];
        actM   <= expClamp;
      end
    end
  end

  always_comb begin
    strobes.refTick = actSel ? busTick : oscTick;
    strobes.gateOn  = cfgGate;
    strobes.divExp  = actM;
  end

  // R6: settings frozen while the gate is on, except at a divided-tick boundary
  p_hold_settings_r6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgGate && !wrapNow) |=> ($stable(actM) && $stable(actSel)));

  // R4: the active exponent never exceeds the cap
  p_exp_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    actM <= EXP_CAP);
endmodule

// File: rtl/pwm_pair_clksrc_dp.sv
module pwm_pair_clksrc_dp
  import pwm_pair_clksrc_pkg::*;
#(
  parameter int MAX_EXP = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  pairStrobe_t strobes,
  output logic        wrapNow,
  output logic        srcTick
);
  localparam int CNT_W = (MAX_EXP < 1) ? 1 : MAX_EXP;
  localparam logic [CNT_W-1:0] ALL_ONES = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] lim;
  logic [EXP_W-1:0] shiftAmt;

  assign shiftAmt = EXP_W'(CNT_W) - strobes.divExp;
  assign lim      = ALL_ONES >> shiftAmt;
  assign wrapNow  = strobes.gateOn && strobes.refTick && (cnt == lim);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cnt     <= '0;
      srcTick <= 1'b0;
    end else if (!strobes.gateOn) begin
      cnt     <= '0;
      srcTick <= 1'b0;
    end else if (strobes.refTick) begin
      if (cnt == lim) begin
        cnt     <= '0;
        srcTick <= 1'b1;
      end else begin
        cnt     <= cnt + 1'b1;
        srcTick <= 1'b0;
      end
    end else begin
      srcTick <= 1'b0;
    end
  end

  // R2: gate closed means no tick and a cleared count on the next cycle
  p_gate_quiet_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.gateOn |=> (!srcTick && cnt == '0));

  // R1: every output tick follows a tick of the selected reference
  p_tick_from_ref_r1: assert property (@(posedge clk) disable iff (!rstN)
    srcTick |-> $past(strobes.refTick));

  // R3: the count stays within the current division limit
  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    cnt <= lim);
endmodule

// File: rtl/pwm_pair_clksrc.sv
module pwm_pair_clksrc
  import pwm_pair_clksrc_pkg::*;
#(
  parameter int CFG_W   = 8,
  parameter int MAX_EXP = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             oscTick,
  input  logic             busTick,
  input  logic [CFG_W-1:0] cfgWord,
  output logic             srcTick,
  output logic             bypassEven,
  output logic             bypassOdd
);
  pairStrobe_t strobes;
  logic        wrapNow;

  pwm_pair_clksrc_ctrl #(.CFG_W(CFG_W), .MAX_EXP(MAX_EXP)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .oscTick    (oscTick),
    .busTick    (busTick),
    .cfgWord    (cfgWord),
    .wrapNow    (wrapNow),
    .strobes    (strobes),
    .bypassEven (bypassEven),
    .bypassOdd  (bypassOdd)
  );

  pwm_pair_clksrc_dp #(.MAX_EXP(MAX_EXP)) dp_i (
    .clk     (clk),
    .rstN    (rstN),
    .strobes (strobes),
    .wrapNow (wrapNow),
    .srcTick (srcTick)
  );

  // R5: bypass flags mirror their configuration bits one cycle later
  p_bypass_follow_r5: assert property (@(posedge clk) disable iff (!rstN)
    ##1 (bypassEven == $past(cfgWord[BYP_EVEN_BIT])) &&
        (bypassOdd  == $past(cfgWord[BYP_ODD_BIT])));
endmodule

// File: tb/pwm_pair_clksrc_tb_top.sv
`timescale 1ns/1ps
module pwm_pair_clksrc_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       oscTick = 1'b0;
  logic       busTick = 1'b0;
  logic [7:0] cfgWord = 8'h00;
  logic       srcTick;
  logic       bypassEven;
  logic       bypassOdd;

  int oscP = 1, busP = 0, oscPh = 0, busPh = 0;
  int total = 0, fails = 0, cyc = 0;

  localparam int NVEC = 8;
  localparam logic [7:0] V_CFG [NVEC] = '{8'h10, 8'h12, 8'h91, 8'h13, 8'h98, 8'h1F, 8'h1A, 8'h82};
  localparam int V_OSC [NVEC] = '{1, 1, 1, 2, 1, 1, 2, 5};
  localparam int V_BUS [NVEC] = '{0, 0, 3, 7, 3, 0, 0, 2};
  localparam int V_GAP [NVEC] = '{1, 4, 6, 16, 768, 256, 512, 0};
  localparam string V_REQ [NVEC] = '{"R3", "R3", "R1", "R3", "R3", "R4", "R4", "R2"};

  always #2.5 clk = ~clk;

  pwm_pair_clksrc dut_i (
    .clk(clk), .rstN(rstN), .oscTick(oscTick), .busTick(busTick),
    .cfgWord(cfgWord), .srcTick(srcTick),
    .bypassEven(bypassEven), .bypassOdd(bypassOdd)
  );

  always @(negedge clk) begin
    oscTick = (oscP != 0) && (oscPh == 0);
    oscPh   = (oscPh + 1 >= oscP) ? 0 : oscPh + 1;
    busTick = (busP != 0) && (busPh == 0);
    busPh   = (busPh + 1 >= busP) ? 0 : busPh + 1;
  end

  task automatic report();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; fails++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      report();
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // counts falling edges until srcTick is seen high; returns 0 on timeout
  task automatic waitPulse(input int limit, output int n);
    int k = 0;
    do begin
      @(negedge clk);
      k++;
    end while (!srcTick && k < limit);
    n = srcTick ? k : 0;
  endtask

  task automatic quietFor(input int cycles, output int seen);
    seen = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (srcTick) seen++;
    end
  endtask

  initial begin
    int n, seen;
    repeat (3) @(negedge clk);
    // R7: reset state
    chk(srcTick == 1'b0, "R7 srcTick", srcTick, 0);
    chk(bypassEven == 1'b0, "R7 bypassEven", bypassEven, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(bypassOdd == 1'b0, "R7 bypassOdd", bypassOdd, 0);

    // table: division ratio per configuration
    for (int v = 0; v < NVEC; v++) begin
      cfgWord = V_CFG[v] & 8'hEF;
      oscP = V_OSC[v]; busP = V_BUS[v];
      repeat (4) @(negedge clk);
      cfgWord = V_CFG[v];
      if (V_GAP[v] == 0) begin
        quietFor(300, seen);
        chk(seen == 0, V_REQ[v], seen, 0);
      end else begin
        waitPulse(2000, n);
        waitPulse(2000, n);
        chk(n == V_GAP[v], V_REQ[v], n, V_GAP[v]);
      end
    end

    // R1: bus selected but bus ticks absent, osc active -> silent
    cfgWord = 8'h80; oscP = 1; busP = 0;
    repeat (4) @(negedge clk);
    cfgWord = 8'h90;
    quietFor(200, seen);
    chk(seen == 0, "R1 unselected osc ignored", seen, 0);

    // R2: gate off stops ticks; restart takes 2^m reference ticks
    cfgWord = 8'h02; oscP = 1;
    repeat (4) @(negedge clk);
    cfgWord = 8'h12;
    waitPulse(100, n);
    repeat (2) @(negedge clk);
    cfgWord = 8'h02;
    quietFor(50, seen);
    chk(seen == 0, "R2 gate off silent", seen, 0);
    cfgWord = 8'h12;
    waitPulse(100, n);
    chk(n == 4, "R2 restart latency", n, 4);

    // R6: exponent change waits for boundary
    cfgWord = 8'h03;
    repeat (4) @(negedge clk);
    cfgWord = 8'h13;
    waitPulse(100, n);
    cfgWord = 8'h10;
    waitPulse(100, n);
    chk(n == 8, "R6 old period completes", n, 8);
    waitPulse(100, n);
    chk(n == 1, "R6 new exponent applied", n, 1);

    // R6: source change waits for boundary, then silent bus applies
    cfgWord = 8'h13;
    waitPulse(100, n);
    waitPulse(100, n);
    cfgWord = 8'h93;
    waitPulse(100, n);
    chk(n == 8, "R6 old source finishes period", n, 8);
    quietFor(100, seen);
    chk(seen == 0, "R6 new source applied", seen, 0);

    // R5: bypass bits, with gate off and with gate on
    cfgWord = 8'h20;
    @(negedge clk);
    chk(bypassEven == 1'b1 && bypassOdd == 1'b0, "R5 even set",
        {bypassOdd, bypassEven}, 1);
    cfgWord = 8'h50;
    @(negedge clk);
    chk(bypassEven == 1'b0 && bypassOdd == 1'b1, "R5 odd set",
        {bypassOdd, bypassEven}, 2);
    cfgWord = 8'h00;
    @(negedge clk);
    chk(bypassEven == 1'b0 && bypassOdd == 1'b0, "R5 both clear",
        {bypassOdd, bypassEven}, 0);

    report();
  end
endmodule